// File: doc/BRIEF.md
# ADC channel scan controller

This block is the digital sequencer that sits in front of an eight-input successive-approximation converter. Software writes one control word made of three fields: a channel mask, a clock divider and a burst flag, plus a three-bit start code. From the bus clock the block derives a converter tick, which is a single-cycle enable pulse that fires once every divider-plus-one bus cycles. Each conversion lasts eleven ticks.

The block works in one of two ways. In single mode, a write of start code 1 converts the lowest selected input once and then returns to idle. In burst mode, the selected inputs are converted one after another with no gap, from the lowest set mask bit upward, and the scan wraps around after the highest one. Each input has its own result register, which holds a 10-bit value and a done flag. A read clears the done flag, and the interrupt output stays high while any done flag is set.

The analog converter is modelled by a behavioural stub. At the start of a conversion the stub captures the selected input's 10-bit value, and it returns that value when the eleventh tick arrives. After reset the mask is 0x01, the divider is 0 and burst is off.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, irq is low and every result register reads done = 0 with data 0.
- R2: A channel mask of 0x00 behaves exactly like 0x01: only input 0 is converted.
- R3: The converter tick fires once every cfg_div+1 bus cycles. After a single start is written, the result of one conversion (11 ticks) appears between 10*(div+1)+2 and 11*(div+1)+1 bus cycles after the write edge.
- R4: A write with cfg_start = 3'b001 and cfg_burst = 0 converts the lowest set bit of the mask exactly once; no further result follows.
- R5: With cfg_burst = 1 and cfg_start = 0, inputs are converted in ascending order of set mask bits (bit n is input n), starting at the lowest set bit and wrapping from the highest set bit back to the lowest.
- R6: In burst mode, successive results arrive exactly 11*(div+1) bus cycles apart, with no idle tick between conversions.
- R7: Clearing cfg_burst lets the conversion in progress finish and store its result; no conversion starts afterwards.
- R8: While burst = 1 and the start code is nonzero, no conversion begins. A later write with start code 0 and burst = 1 starts scanning.
- R9: Each input's register keeps its most recent result. Its done flag is set when that result is written and cleared by a read of that input (rd_en with rd_ch = n). irq is high while any done flag is set.
- R10: The stored result equals the input's 10-bit value ain[10n+9:10n] captured when its conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 8 | Channel mask, bit n selects input n |
| cfg_div | input | 8 | Converter tick divider (period div+1) |
| cfg_burst | input | 1 | Continuous scan enable |
| cfg_start | input | 3 | Start code, 1 = single conversion |
| ain | input | 80 | Analog stand-in values, input n at bits 10n+9:10n |
| rd_en | input | 1 | Result read strobe, clears the done flag |
| rd_ch | input | 3 | Input whose result is read |
| rd_data | output | 10 | Result of the addressed input |
| rd_done | output | 1 | Done flag of the addressed input |
| irq | output | 1 | High while any done flag is set |

## Verification
Single conversions are run across a set of masks (a single bit, zero, several bits, the top bit) and dividers from 0 to 5. This shows that lowest-bit selection, the zero-mask fallback and the tick period are each handled independently. A burst over a sparse mask (inputs 1, 2 and 5) shows the ascending order and the wrap, and the spacing of its results separates back-to-back operation from one that idles between conversions. Stopping burst mid-conversion, burst with a nonzero start code, and two pending results read in turn cover the drain, blocking and done-flag rules.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int DEF_NCH       = 8;
    localparam int DEF_RESW      = 10;
    localparam int DEF_DIVW      = 8;
    localparam int DEF_STW       = 3;
    localparam int DEF_CONV_CLKS = 11;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int DIVW = adc_scan_pkg::DEF_DIVW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt >= div);
        if (tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
    parameter int NCH       = adc_scan_pkg::DEF_NCH,
    parameter int RESW      = adc_scan_pkg::DEF_RESW,
    parameter int CONV_CLKS = adc_scan_pkg::DEF_CONV_CLKS,
    localparam int CHW      = $clog2(NCH),
    localparam int CNTW     = $clog2(CONV_CLKS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic [CHW-1:0]      start_ch,
    input  logic [NCH*RESW-1:0] ain,
    output logic                busy,
    output logic                done,
    output logic [CHW-1:0]      done_ch,
    output logic [RESW-1:0]     result
);
    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
        logic [CHW-1:0]  ch;
        logic [RESW-1:0] smp;
    } stub_st_t;

    stub_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = s_q.busy && tick && (s_q.cnt == CNTW'(CONV_CLKS - 1));
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.ch   = start_ch;
            s_d.smp  = ain[int'(start_ch)*RESW +: RESW];
        end else if (done) begin
            s_d.busy = 1'b0;
        end else if (s_q.busy && tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    assign busy    = s_q.busy;
    assign done_ch = s_q.ch;
    assign result  = s_q.smp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NCH  = adc_scan_pkg::DEF_NCH,
    parameter int RESW = adc_scan_pkg::DEF_RESW,
    localparam int CHW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [CHW-1:0]  wr_ch,
    input  logic [RESW-1:0] wr_data,
    input  logic            rd_en,
    input  logic [CHW-1:0]  rd_ch,
    output logic [RESW-1:0] rd_data,
    output logic            rd_done,
    output logic            irq
);
    typedef struct packed {
        logic [NCH-1:0][RESW-1:0] res;
        logic [NCH-1:0]           flag;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int n = 0; n < NCH; n++) begin
            if (rd_en && (rd_ch == CHW'(n))) begin
                s_d.flag[n] = 1'b0;
            end
            if (wr && (wr_ch == CHW'(n))) begin
                s_d.res[n]  = wr_data;
                s_d.flag[n] = 1'b1;
            end
        end
    end

    assign rd_data = s_q.res[rd_ch];
    assign rd_done = s_q.flag[rd_ch];
    assign irq     = |s_q.flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
    parameter int NCH       = adc_scan_pkg::DEF_NCH,
    parameter int RESW      = adc_scan_pkg::DEF_RESW,
    parameter int DIVW      = adc_scan_pkg::DEF_DIVW,
    parameter int STW       = adc_scan_pkg::DEF_STW,
    parameter int CONV_CLKS = adc_scan_pkg::DEF_CONV_CLKS,
    localparam int CHW      = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [NCH-1:0]      cfg_sel,
    input  logic [DIVW-1:0]     cfg_div,
    input  logic                cfg_burst,
    input  logic [STW-1:0]      cfg_start,
    input  logic [NCH*RESW-1:0] ain,
    input  logic                rd_en,
    input  logic [CHW-1:0]      rd_ch,
    output logic [RESW-1:0]     rd_data,
    output logic                rd_done,
    output logic                irq
);
    import adc_scan_pkg::*;

    localparam logic [STW-1:0] START_ONCE = STW'(1);

    typedef struct packed {
        logic [NCH-1:0]  sel;
        logic [DIVW-1:0] div;
        logic            burst;
        logic [STW-1:0]  start;
        logic            sw_req;
        seq_state_e      state;
        logic [CHW-1:0]  ch;
    } ctl_st_t;

    ctl_st_t s_d, s_q;

    logic            tick;
    logic            conv_start;
    logic [CHW-1:0]  start_ch;
    logic            conv_done;
    logic [CHW-1:0]  done_ch;
    logic [RESW-1:0] conv_result;
    logic            stub_busy;
    logic            burst_run;
    logic [NCH-1:0]  scan_mask;

    function automatic logic [CHW-1:0] first_set(input logic [NCH-1:0] m);
        first_set = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) first_set = CHW'(i);
        end
    endfunction

    function automatic logic [CHW-1:0] next_set(input logic [NCH-1:0] m,
                                                input logic [CHW-1:0] cur);
        next_set = first_set(m);
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i] && (i > int'(cur))) next_set = CHW'(i);
        end
    endfunction

    assign scan_mask = (s_q.sel == '0) ? NCH'(1) : s_q.sel;
    assign burst_run = s_q.burst && (s_q.start == '0);

    always_comb begin
        s_d        = s_q;
        conv_start = 1'b0;
        start_ch   = first_set(scan_mask);

        unique case (s_q.state)
            SEQ_IDLE: begin
                if (burst_run) begin
                    conv_start = 1'b1;
                    s_d.ch     = start_ch;
                    s_d.state  = SEQ_BUSY;
                end else if (s_q.sw_req) begin
                    conv_start = 1'b1;
                    s_d.ch     = start_ch;
                    s_d.sw_req = 1'b0;
                    s_d.state  = SEQ_BUSY;
                end
            end
            SEQ_BUSY: begin
                if (conv_done) begin
                    if (burst_run) begin
                        conv_start = 1'b1;
                        start_ch   = next_set(scan_mask, s_q.ch);
                        s_d.ch     = start_ch;
                    end else if (s_q.sw_req) begin
                        conv_start = 1'b1;
                        s_d.ch     = start_ch;
                        s_d.sw_req = 1'b0;
                    end else begin
                        s_d.state = SEQ_IDLE;
                    end
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase

        if (cfg_we) begin
            s_d.sel   = cfg_sel;
            s_d.div   = cfg_div;
            s_d.burst = cfg_burst;
            s_d.start = cfg_start;
            if (cfg_burst) begin
                s_d.sw_req = 1'b0;
            end else if (cfg_start == START_ONCE) begin
                s_d.sw_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.sel    <= NCH'(1);
            s_q.state  <= SEQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    adc_tick_gen #(.DIVW(DIVW)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (s_q.div),
        .tick  (tick)
    );

    adc_conv_stub #(.NCH(NCH), .RESW(RESW), .CONV_CLKS(CONV_CLKS)) i_stub (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (conv_start),
        .start_ch (start_ch),
        .ain      (ain),
        .busy     (stub_busy),
        .done     (conv_done),
        .done_ch  (done_ch),
        .result   (conv_result)
    );

    adc_result_bank #(.NCH(NCH), .RESW(RESW)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (conv_done),
        .wr_ch   (done_ch),
        .wr_data (conv_result),
        .rd_en   (rd_en),
        .rd_ch   (rd_ch),
        .rd_data (rd_data),
        .rd_done (rd_done),
        .irq     (irq)
    );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
    parameter int NCH  = adc_scan_pkg::DEF_NCH,
    parameter int DIVW = adc_scan_pkg::DEF_DIVW,
    parameter int STW  = adc_scan_pkg::DEF_STW,
    localparam int CHW = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            burst_cur,
    input logic [STW-1:0]  start_cur,
    input logic [NCH-1:0]  sel_cur,
    input logic [DIVW-1:0] div_cur,
    input logic            cfg_we,
    input logic            tick,
    input logic            conv_start,
    input logic [CHW-1:0]  start_ch,
    input logic            conv_done,
    input logic            stub_busy,
    input logic            irq
);
    AST_BLOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_cur && (start_cur != '0) && !stub_busy) |-> !conv_start); // R8

    AST_START_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ((sel_cur == '0) ? (start_ch == '0) : sel_cur[start_ch])); // R2

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_cur != '0) && !cfg_we) |=> !tick); // R3

    AST_INFLIGHT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (stub_busy && !conv_done && !conv_start) |=> stub_busy); // R7

    AST_NO_RESTART_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (stub_busy && !conv_done) |-> !conv_start); // R6

    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> irq); // R9
endmodule

bind adc_scan_ctrl adc_scan_chk #(.NCH(NCH), .DIVW(DIVW), .STW(STW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_cur  (s_q.burst),
    .start_cur  (s_q.start),
    .sel_cur    (s_q.sel),
    .div_cur    (s_q.div),
    .cfg_we     (cfg_we),
    .tick       (tick),
    .conv_start (conv_start),
    .start_ch   (start_ch),
    .conv_done  (conv_done),
    .stub_busy  (stub_busy),
    .irq        (irq)
);

// File: tb/test_adc_scan_ctrl.sv
module test_adc_scan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_sel = '0;
    logic [7:0]  cfg_div = '0;
    logic        cfg_burst = 1'b0;
    logic [2:0]  cfg_start = '0;
    logic [79:0] ain;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_ch = '0;
    logic [9:0]  rd_data;
    logic        rd_done;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    adc_scan_ctrl i_adc_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_div(cfg_div), .cfg_burst(cfg_burst), .cfg_start(cfg_start),
        .ain(ain), .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data),
        .rd_done(rd_done), .irq(irq)
    );

    // sel[18:11], div[10:3], expected channel[2:0]
    localparam logic [18:0] VEC [6] = '{
        {8'h01, 8'd0, 3'd0},
        {8'h00, 8'd0, 3'd0},
        {8'h08, 8'd1, 3'd3},
        {8'h90, 8'd3, 3'd4},
        {8'h80, 8'd0, 3'd7},
        {8'hFF, 8'd5, 3'd0}
    };

    function automatic logic [9:0] ainv(input int c);
        return 10'((c * 101 + 17) % 1024);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] s, input logic [7:0] d,
                      input logic b, input logic [2:0] st);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_div = d; cfg_burst = b; cfg_start = st;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int c, output logic [9:0] d, output logic dn);
        rd_en = 1'b1;
        rd_ch = 3'(c);
        #1;
        d  = rd_data;
        dn = rd_done;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_irq(input int lim, output int n);
        n = 0;
        while (!irq && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic quiet(input int len, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
    endtask

    task automatic scan(output int got, output logic [9:0] gd);
        logic [9:0] d;
        logic dn;
        got = -1;
        gd  = '0;
        for (int c = 0; c < 8; c++) begin
            rd(c, d, dn);
            if (dn && got < 0) begin
                got = c;
                gd  = d;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n, got, prev, t, lo, hi;
        bit seen;
        logic [9:0] d, gd;
        logic dn;
        int exp_order [5] = '{1, 2, 5, 1, 2};

        for (int c = 0; c < 8; c++) ain[c*10 +: 10] = ainv(c);

        // R1 reset state
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R1", "irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 8; c++) begin
            rd(c, d, dn);
            check(dn == 1'b0 && d == '0, "R1", "result after reset", int'({dn, d}), 0);
        end

        // Single conversions from the vector table (R2 R3 R4 R10)
        for (int i = 0; i < 6; i++) begin
            int ch;
            int dv;
            ch = int'(VEC[i][2:0]);
            dv = int'(VEC[i][10:3]);
            wr(VEC[i][18:11], VEC[i][10:3], 1'b0, 3'd1);
            wait_irq(400, n);
            lo = 10 * (dv + 1) + 2;
            hi = 11 * (dv + 1) + 1;
            check(n >= lo && n <= hi, "R3", "conversion latency", n, hi);
            rd(ch, d, dn);
            check(dn == 1'b1, "R2 R4", "done on lowest selected", int'(dn), 1);
            check(d == ainv(ch), "R10", "result value", int'(d), int'(ainv(ch)));
            check(irq == 1'b0, "R4", "only one input converted", int'(irq), 0);
            quiet(40, seen);
            check(!seen, "R4", "no repeat after single start", int'(seen), 0);
        end

        // Burst order, wrap and spacing (R5 R6)
        wr(8'h26, 8'd2, 1'b1, 3'd0);
        prev = 0;
        for (int k = 0; k < 5; k++) begin
            wait_irq(200, n);
            t = cyc;
            if (k > 0) check(t - prev == 33, "R6", "burst spacing", t - prev, 33);
            prev = t;
            scan(got, gd);
            check(got == exp_order[k], "R5", "burst order", got, exp_order[k]);
            check(gd == ainv(exp_order[k]), "R10", "burst result", int'(gd),
                  int'(ainv(exp_order[k])));
        end

        // Stop burst with input 5 in flight (R7)
        wr(8'h26, 8'd2, 1'b0, 3'd0);
        wait_irq(200, n);
        check(irq == 1'b1, "R7", "in-flight result stored", int'(irq), 1);
        scan(got, gd);
        check(got == 5, "R7", "in-flight input", got, 5);
        quiet(150, seen);
        check(!seen, "R7", "no conversion after stop", int'(seen), 0);

        // Burst blocked by nonzero start code (R8)
        wr(8'hFF, 8'd0, 1'b1, 3'd3);
        quiet(150, seen);
        check(!seen, "R8", "blocked burst", int'(seen), 0);
        wr(8'hFF, 8'd0, 1'b1, 3'd0);
        wait_irq(40, n);
        check(irq == 1'b1, "R8", "burst starts after start code 0", int'(irq), 1);
        scan(got, gd);
        check(got == 0, "R5", "burst begins at lowest", got, 0);
        wr(8'hFF, 8'd0, 1'b0, 3'd0);
        quiet(40, seen);
        scan(got, gd);
        scan(got, gd);
        check(irq == 1'b0, "R9", "irq low after draining", int'(irq), 0);

        // Two pending flags, clear on read (R9)
        wr(8'h08, 8'd0, 1'b0, 3'd1);
        quiet(20, seen);
        wr(8'h10, 8'd0, 1'b0, 3'd1);
        quiet(20, seen);
        check(irq == 1'b1, "R9", "irq with pending flags", int'(irq), 1);
        rd(3, d, dn);
        check(dn == 1'b1, "R9", "input 3 done", int'(dn), 1);
        check(irq == 1'b1, "R9", "irq held by input 4", int'(irq), 1);
        rd(4, d, dn);
        check(dn == 1'b1 && d == ainv(4), "R9", "input 4 result", int'(d), int'(ainv(4)));
        check(irq == 1'b0, "R9", "irq after both read", int'(irq), 0);
        rd(4, d, dn);
        check(dn == 1'b0, "R9", "done cleared by read", int'(dn), 0);
        check(d == ainv(4), "R9", "result kept after read", int'(d), int'(ainv(4)));

        // Latest result replaces the old one (R9 R10)
        ain[9:0] = 10'h3A5;
        wr(8'h01, 8'd0, 1'b0, 3'd1);
        wait_irq(100, n);
        rd(0, d, dn);
        check(dn == 1'b1 && d == 10'h3A5, "R9", "most recent result", int'(d), 10'h3A5);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule